// File: doc/BRIEF.md
# Receive descriptor write-back engine

This block sits on the completion side of a network receive ring. Software hands descriptors to the hardware by moving a tail index forward. Each time a received packet finishes, an upstream completion record arrives on a valid/ready input. The engine takes the descriptor at the head of the ring, packs the packet's length, checksum, VLAN tag, status and error flags into a 128-bit write-back word, and issues it on a valid/ready memory-write port. The port carries the ring slot index and a byte mask. The head then moves forward by one.

Two write-back layouts exist, chosen by one enable bit in a control register. In the compact layout only the upper 64 bits are written, so the buffer address that software stored in the lower half survives. In the wide layout all 128 bits are replaced. That layout adds a queue field and an IP identification field, and its status and error fields grow to 20 and 12 bits. A completion that finds no descriptor owned by hardware is dropped and counted. When a write-back leaves the free count at or below a programmable threshold, a sticky interrupt cause bit is raised. Software clears it by writing a one.

Back-pressure rules: `cmp_ready` is high whenever the output register is empty or is being drained in the same cycle (`!wb_valid || wb_ready`). A completion is taken when `cmp_valid && cmp_ready`. Once `wb_valid` is high, the index, data and mask hold steady until a cycle with `wb_ready` high.

Top module: `rxwb_engine`

## Requirements
- R1: After reset the head and tail are 0, `wb_valid` is 0, the missed counter is 0, the interrupt cause is 0 and the wide layout is off.
- R2: In compact mode the write-back word is {vlan[127:112], err8[111:104], stat8[103:96], csum[95:80], len[79:64], zeros[63:0]} and the mask is 16'hFF00, so bytes 0–7 are left untouched. stat8 is {cmp_stat[7:1], 1'b1}, so the done flag in bit 0 is always set. err8 is cmp_err with bits 3 and 4 forced to 0.
- R3: In wide mode the word is mrq[31:0], ipid[47:32], csum[63:48], stat20[83:64], err12[95:84], len[111:96], vlan[127:112], and the mask is 16'hFFFF.
- R4: In wide mode stat20 holds stat8 in bits 7:0, the valid-IP-id flag in bit 9, the valid-UDP-checksum flag in bit 10 and the TCP-ACK flag in bit 15, with every other bit at 0. err12 holds err8 in bits 7:0 and zero in bits 11:8.
- R5: A write with `reg_sel`=1 stores `reg_wdata[15]` as the wide-layout enable. `ctrl_rd` returns only that bit, at bit 15, with all other bits 0. The layout is fixed at the cycle the completion is taken.
- R6: A write with `reg_sel`=0 loads the tail from the low index bits of `reg_wdata`. Each write-back goes to slot `head`, and the head then advances by one modulo the ring depth.
- R7: When head equals tail, a completion is still taken. Nothing is written back, and `miss_cnt` increases by one.
- R8: `cmp_ready` equals `!wb_valid || wb_ready`. While `wb_valid && !wb_ready`, the output holds its values.
- R9: A write with `reg_sel`=2 sets the threshold. A write-back that leaves (tail − new head) mod depth at or below the threshold sets `irq_cause` bit 4, and that bit stays set.
- R10: A write with `reg_sel`=3 and `reg_wdata[4]`=1 clears `irq_cause` bit 4. If a set occurs in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 tail, 1 control, 2 threshold, 3 cause clear |
| reg_wdata | input | 32 | Register write data |
| ctrl_rd | output | 32 | Control register read value |
| cmp_valid | input | 1 | Completion record valid |
| cmp_ready | output | 1 | Completion record accepted |
| cmp_len | input | 16 | Packet length |
| cmp_csum | input | 16 | Packet checksum |
| cmp_vlan | input | 16 | VLAN tag |
| cmp_ipid | input | 16 | IP identification |
| cmp_mrq | input | 32 | Receive-queue field |
| cmp_stat | input | 8 | Compact status flags (bit 0 ignored) |
| cmp_err | input | 8 | Error flags (bits 3,4 ignored) |
| cmp_ipiv | input | 1 | Valid IP identification flag |
| cmp_udpv | input | 1 | Valid UDP checksum flag |
| cmp_ack | input | 1 | TCP ACK packet flag |
| wb_valid | output | 1 | Write-back valid |
| wb_ready | input | 1 | Write-back accepted |
| wb_idx | output | 4 | Ring slot written |
| wb_data | output | 128 | Write-back word |
| wb_mask | output | 16 | Byte enables |
| head_idx | output | 4 | Current head index |
| miss_cnt | output | 16 | Dropped completions |
| irq_cause | output | 32 | Interrupt cause, bit 4 low-free |

## Verification
The threshold crossing and the software clear of the cause bit can fall in the same cycle. A directed case lines up a write-one-to-clear on the very cycle that a completion drops the free count to the threshold, and the bench expects bit 4 to stay set. A later clear with no completion is expected to drop it. A tail write can also coincide with a taken completion. A random phase with a fixed seed does this often, keeps the tail legal relative to the advancing head, and compares the pointer, the written slot and the interrupt against a cycle model that uses the old tail for the free count.

// File: rtl/rxwb_pkg.sv
package rxwb_pkg;
  localparam int WORD_W = 128;
  localparam int MASK_W = WORD_W / 8;

  typedef struct packed {
    logic [15:0] len;
    logic [15:0] csum;
    logic [15:0] vlan;
    logic [15:0] ipid;
    logic [31:0] mrq;
    logic [7:0]  stat;
    logic [7:0]  err;
    logic        ipiv;
    logic        udpv;
    logic        ack;
  } cmp_rec_t;

  typedef enum logic [1:0] {
    SEL_TAIL  = 2'd0,
    SEL_CTRL  = 2'd1,
    SEL_THR   = 2'd2,
    SEL_CAUSE = 2'd3
  } reg_sel_e;

  localparam int EXT_BIT   = 15;
  localparam int LOWF_BIT  = 4;
endpackage

// File: rtl/rxwb_ring.sv
module rxwb_ring #(
  parameter int DEPTH  = 16,
  parameter int MISS_W = 16,
  localparam int IDXW  = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tail_we,
  input  logic [IDXW-1:0] tail_wdata,
  input  logic            take,
  output logic            avail,
  output logic            consume,
  output logic [IDXW-1:0] head,
  output logic [IDXW-1:0] free_after,
  output logic [MISS_W-1:0] miss_cnt
);
  logic [IDXW-1:0] tail_q;
  logic [IDXW-1:0] free_now;

  assign free_now   = tail_q - head;
  assign avail      = (free_now != '0);
  assign consume    = take && avail;
  assign free_after = free_now - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head     <= '0;
      tail_q   <= '0;
      miss_cnt <= '0;
    end else begin
      if (consume) head <= head + 1'b1;
      if (take && !avail) miss_cnt <= miss_cnt + 1'b1;
      if (tail_we) tail_q <= tail_wdata;
    end
  end

  p_head_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    consume |=> head == $past(head) + 1'b1);
  p_miss_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !avail) |=> (miss_cnt == $past(miss_cnt) + 1'b1) && (head == $past(head)));
endmodule

// File: rtl/rxwb_format.sv
module rxwb_format
  import rxwb_pkg::*;
(
  input  logic               ext_mode,
  input  cmp_rec_t           rec,
  output logic [WORD_W-1:0]  word,
  output logic [MASK_W-1:0]  mask
);
  logic [7:0]  st8;
  logic [7:0]  er8;
  logic [19:0] st20;
  logic [11:0] er12;
  logic [WORD_W-1:0] w_compact;
  logic [WORD_W-1:0] w_wide;

  always_comb begin
    st8  = {rec.stat[7:1], 1'b1};
    er8  = {rec.err[7:5], 2'b00, rec.err[2:0]};
    st20 = '0;
    st20[7:0] = st8;
    st20[9]   = rec.ipiv;
    st20[10]  = rec.udpv;
    st20[15]  = rec.ack;
    er12 = {4'b0000, er8};
    w_compact = {rec.vlan, er8, st8, rec.csum, rec.len, 64'd0};
    w_wide    = {rec.vlan, rec.len, er12, st20, rec.csum, rec.ipid, rec.mrq};
  end

  assign word = ext_mode ? w_wide : w_compact;
  assign mask = ext_mode ? {MASK_W{1'b1}} : {{(MASK_W/2){1'b1}}, {(MASK_W/2){1'b0}}};

  logic unused_bits;
  assign unused_bits = ^{rec.stat[0], rec.err[4:3]};
endmodule

// File: rtl/rxwb_irq.sv
module rxwb_irq #(
  parameter int IDXW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            consume,
  input  logic [IDXW-1:0] free_after,
  input  logic [IDXW-1:0] thresh,
  input  logic            clr,
  output logic            cause
);
  logic set_evt;
  assign set_evt = consume && (free_after <= thresh);

  always_ff @(posedge clk) begin
    if (!rst_n)       cause <= 1'b0;
    else if (set_evt) cause <= 1'b1;
    else if (clr)     cause <= 1'b0;
  end

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cause && !clr) |=> cause);
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> cause);
endmodule

// File: rtl/rxwb_out.sv
module rxwb_out
  import rxwb_pkg::*;
#(
  parameter int IDXW = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [IDXW-1:0]    in_idx,
  input  logic [WORD_W-1:0]  in_data,
  input  logic [MASK_W-1:0]  in_mask,
  output logic               space,
  output logic               wb_valid,
  input  logic               wb_ready,
  output logic [IDXW-1:0]    wb_idx,
  output logic [WORD_W-1:0]  wb_data,
  output logic [MASK_W-1:0]  wb_mask
);
  assign space = !wb_valid || wb_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
      wb_idx   <= '0;
      wb_data  <= '0;
      wb_mask  <= '0;
    end else if (space) begin
      wb_valid <= load;
      if (load) begin
        wb_idx  <= in_idx;
        wb_data <= in_data;
        wb_mask <= in_mask;
      end
    end
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> wb_valid && $stable(wb_data) && $stable(wb_idx) && $stable(wb_mask));
  p_done_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> ((wb_mask == {MASK_W{1'b1}}) ? wb_data[64] : wb_data[96]));
endmodule

// File: rtl/rxwb_engine.sv
module rxwb_engine
  import rxwb_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int MISS_W = 16,
  localparam int IDXW  = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [1:0]         reg_sel,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        ctrl_rd,
  input  logic               cmp_valid,
  output logic               cmp_ready,
  input  logic [15:0]        cmp_len,
  input  logic [15:0]        cmp_csum,
  input  logic [15:0]        cmp_vlan,
  input  logic [15:0]        cmp_ipid,
  input  logic [31:0]        cmp_mrq,
  input  logic [7:0]         cmp_stat,
  input  logic [7:0]         cmp_err,
  input  logic               cmp_ipiv,
  input  logic               cmp_udpv,
  input  logic               cmp_ack,
  output logic               wb_valid,
  input  logic               wb_ready,
  output logic [IDXW-1:0]    wb_idx,
  output logic [WORD_W-1:0]  wb_data,
  output logic [MASK_W-1:0]  wb_mask,
  output logic [IDXW-1:0]    head_idx,
  output logic [MISS_W-1:0]  miss_cnt,
  output logic [31:0]        irq_cause
);
  logic            ext_q;
  logic [IDXW-1:0] thr_q;
  logic            take, avail, consume, space, cause;
  logic [IDXW-1:0] free_after;
  cmp_rec_t        rec;
  logic [WORD_W-1:0] fmt_word;
  logic [MASK_W-1:0] fmt_mask;
  reg_sel_e        sel;

  assign sel = reg_sel_e'(reg_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_q <= 1'b0;
      thr_q <= '0;
    end else if (reg_we) begin
      if (sel == SEL_CTRL) ext_q <= reg_wdata[EXT_BIT];
      if (sel == SEL_THR)  thr_q <= reg_wdata[IDXW-1:0];
    end
  end

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[EXT_BIT] = ext_q;
    irq_cause = '0;
    irq_cause[LOWF_BIT] = cause;
  end

  assign rec = '{len: cmp_len, csum: cmp_csum, vlan: cmp_vlan, ipid: cmp_ipid,
                 mrq: cmp_mrq, stat: cmp_stat, err: cmp_err,
                 ipiv: cmp_ipiv, udpv: cmp_udpv, ack: cmp_ack};

  assign cmp_ready = space;
  assign take      = cmp_valid && space;

  rxwb_ring #(.DEPTH(DEPTH), .MISS_W(MISS_W)) u_ring (
    .clk(clk), .rst_n(rst_n),
    .tail_we(reg_we && (sel == SEL_TAIL)),
    .tail_wdata(reg_wdata[IDXW-1:0]),
    .take(take), .avail(avail), .consume(consume),
    .head(head_idx), .free_after(free_after), .miss_cnt(miss_cnt)
  );

  rxwb_format u_fmt (
    .ext_mode(ext_q), .rec(rec), .word(fmt_word), .mask(fmt_mask)
  );

  rxwb_irq #(.IDXW(IDXW)) u_irq (
    .clk(clk), .rst_n(rst_n), .consume(consume), .free_after(free_after),
    .thresh(thr_q), .clr(reg_we && (sel == SEL_CAUSE) && reg_wdata[LOWF_BIT]),
    .cause(cause)
  );

  rxwb_out #(.IDXW(IDXW)) u_out (
    .clk(clk), .rst_n(rst_n), .load(consume), .in_idx(head_idx),
    .in_data(fmt_word), .in_mask(fmt_mask), .space(space),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_idx(wb_idx),
    .wb_data(wb_data), .wb_mask(wb_mask)
  );

  logic unused_wdata;
  assign unused_wdata = ^{reg_wdata[31:16], reg_wdata[14:5], reg_wdata[3:IDXW]};

  p_ready_rule_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_ready == (!wb_valid || wb_ready));
endmodule

// File: tb/rxwb_engine_test.sv
module rxwb_engine_test;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic reg_we = 0; logic [1:0] reg_sel = 0; logic [31:0] reg_wdata = 0;
  logic cmp_valid = 0, wb_ready = 0;
  logic [15:0] cmp_len = 0, cmp_csum = 0, cmp_vlan = 0, cmp_ipid = 0;
  logic [31:0] cmp_mrq = 0; logic [7:0] cmp_stat = 0, cmp_err = 0;
  logic cmp_ipiv = 0, cmp_udpv = 0, cmp_ack = 0;
  logic [31:0] ctrl_rd, irq_cause; logic cmp_ready, wb_valid;
  logic [3:0] wb_idx, head_idx; logic [127:0] wb_data; logic [15:0] wb_mask, miss_cnt;

  rxwb_engine uut (.*);

  int checks = 0, errors = 0;
  logic [3:0] m_head, m_tail, m_thr; logic m_ext, m_cause, m_vld, m_vext;
  logic [15:0] m_miss; logic [127:0] m_data; logic [15:0] m_mask; logic [3:0] m_idx;

  task automatic chk(input logic ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s act=%h exp=%h", tag, act, exp); end
  endtask

  function automatic logic [127:0] exp_word(input logic ext);
    logic [127:0] w; logic [7:0] s8, e8;
    s8 = cmp_stat; s8[0] = 1'b1;
    e8 = cmp_err; e8[4:3] = 2'b00;
    w = '0;
    if (!ext) begin
      w[79:64] = cmp_len; w[95:80] = cmp_csum; w[103:96] = s8;
      w[111:104] = e8; w[127:112] = cmp_vlan;
    end else begin
      w[31:0] = cmp_mrq; w[47:32] = cmp_ipid; w[63:48] = cmp_csum;
      w[71:64] = s8; w[73] = cmp_ipiv; w[74] = cmp_udpv; w[79] = cmp_ack;
      w[91:84] = e8; w[111:96] = cmp_len; w[127:112] = cmp_vlan;
    end
    return w;
  endfunction

  task automatic tick();
    logic acc, avl, cons, setv;
    logic [3:0] fa;
    #1;
    chk(cmp_ready == (!m_vld || wb_ready), "R8 ready", 128'(cmp_ready), 128'(!m_vld || wb_ready));
    acc = cmp_valid && (!m_vld || wb_ready);
    avl = (m_tail - m_head) != 4'd0;
    cons = acc && avl;
    fa = m_tail - m_head - 4'd1;
    setv = cons && (fa <= m_thr);
    if (m_vld && wb_ready) m_vld = 1'b0;
    if (cons) begin
      m_vld = 1'b1; m_vext = m_ext; m_data = exp_word(m_ext);
      m_mask = m_ext ? 16'hFFFF : 16'hFF00; m_idx = m_head; m_head = m_head + 4'd1;
    end
    if (acc && !avl) m_miss = m_miss + 16'd1;
    if (setv) m_cause = 1'b1;
    else if (reg_we && reg_sel == 2'd3 && reg_wdata[4]) m_cause = 1'b0;
    if (reg_we) begin
      case (reg_sel)
        2'd0: m_tail = reg_wdata[3:0];
        2'd1: m_ext = reg_wdata[15];
        2'd2: m_thr = reg_wdata[3:0];
        default: ;
      endcase
    end
    @(posedge clk); #1;
    chk(wb_valid == m_vld, "R8 valid", 128'(wb_valid), 128'(m_vld));
    if (m_vld) begin
      chk(wb_data == m_data, m_vext ? "R3 data" : "R2 data", wb_data, m_data);
      chk(wb_mask == m_mask, m_vext ? "R3 mask" : "R2 mask", 128'(wb_mask), 128'(m_mask));
      chk(wb_idx == m_idx, "R6 slot", 128'(wb_idx), 128'(m_idx));
    end
    chk(head_idx == m_head, "R6 head", 128'(head_idx), 128'(m_head));
    chk(miss_cnt == m_miss, "R7 miss", 128'(miss_cnt), 128'(m_miss));
    chk(irq_cause == {27'd0, m_cause, 4'd0}, "R9 cause", 128'(irq_cause), 128'({27'd0, m_cause, 4'd0}));
    chk(ctrl_rd == {16'd0, m_ext, 15'd0}, "R5 ctrl", 128'(ctrl_rd), 128'({16'd0, m_ext, 15'd0}));
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    reg_we = 1; reg_sel = s; reg_wdata = d;
  endtask

  task automatic idle();
    reg_we = 0; cmp_valid = 0;
  endtask

  task automatic rnd_rec();
    cmp_len = 16'($urandom); cmp_csum = 16'($urandom); cmp_vlan = 16'($urandom);
    cmp_ipid = 16'($urandom); cmp_mrq = $urandom; cmp_stat = 8'($urandom);
    cmp_err = 8'($urandom); cmp_ipiv = 1'($urandom); cmp_udpv = 1'($urandom);
    cmp_ack = 1'($urandom);
  endtask

  logic done = 0;
  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors); $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_head = 0; m_tail = 0; m_thr = 0; m_ext = 0; m_cause = 0; m_vld = 0;
    m_vext = 0; m_miss = 0; m_data = 0; m_mask = 0; m_idx = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    chk(wb_valid == 0 && head_idx == 0 && miss_cnt == 0 && irq_cause == 0 && ctrl_rd == 0,
        "R1 reset", {wb_valid, head_idx, miss_cnt, irq_cause, ctrl_rd}, 128'd0);
    // R7: completion with empty ring is dropped
    rnd_rec(); cmp_valid = 1; wb_ready = 1; tick(); idle(); tick();
    // R5: only enable bit reads back
    wr(2'd1, 32'hFFFF_FFFF); tick(); idle(); tick();
    wr(2'd1, 32'h0); tick();
    // R9/R10: tail 8, threshold 5, third write-back collides with clear
    wr(2'd0, 32'd8); tick(); wr(2'd2, 32'd5); tick(); idle();
    for (int i = 0; i < 2; i++) begin rnd_rec(); cmp_valid = 1; tick(); end
    rnd_rec(); cmp_valid = 1; wr(2'd3, 32'h10); tick(); idle(); tick();
    chk(irq_cause[4] == 1'b1, "R10 set wins", 128'(irq_cause[4]), 128'd1);
    wr(2'd3, 32'h10); tick(); idle(); tick();
    chk(irq_cause[4] == 1'b0, "R10 clear", 128'(irq_cause[4]), 128'd0);
    // R4: wide layout flags
    wr(2'd1, 32'h8000); tick(); idle();
    rnd_rec(); cmp_ipiv = 1; cmp_udpv = 1; cmp_ack = 1; cmp_err = 8'hFF; cmp_valid = 1; tick(); idle();
    chk(wb_data[83:64] == {4'h0, 1'b1, 4'h0, 2'b11, 1'b0, cmp_stat[7:1], 1'b1},
        "R4 status", 128'(wb_data[83:64]), 128'({4'h0, 1'b1, 4'h0, 2'b11, 1'b0, cmp_stat[7:1], 1'b1}));
    chk(wb_data[95:84] == 12'h0E7, "R4 errors", 128'(wb_data[95:84]), 128'h0E7);
    // R8: back-pressure holds output
    wb_ready = 0; rnd_rec(); cmp_valid = 1; tick(); tick(); tick(); wb_ready = 1; idle(); tick();
    // random phase
    for (int c = 0; c < 4000; c++) begin
      logic acc_p, avl_p;
      reg_we = 0; rnd_rec();
      cmp_valid = ($urandom % 3) != 0;
      wb_ready  = ($urandom % 4) != 0;
      acc_p = cmp_valid && (!m_vld || wb_ready);
      avl_p = (m_tail - m_head) != 4'd0;
      case ($urandom % 8)
        0, 1: wr(2'd0, 32'(m_head + 4'((acc_p && avl_p) ? 1 + $urandom % 15 : $urandom % 16)));
        2: wr(2'd1, $urandom);
        3: wr(2'd2, $urandom);
        4: wr(2'd3, $urandom);
        default: ;
      endcase
      tick();
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule